// File: doc/BRIEF.md
# Terminal Status Register Clear Control

This block keeps the two status words of a serial-bus remote terminal, the last-status word and the basic-status word, and the host control bits that clear and set them. A host writes a control word. Two bits of that word are write-one commands. One clears most of the last-status word. The other clears only its busy flag. A busy-option bit chooses which reset events raise the busy flag. A standard-select bit decides what a shared output pin carries.

Message decoding elsewhere supplies the new status contents through a capture strobe. This block applies that capture together with the host commands and the reset events, using a fixed priority. A master reset event returns the control word to zero. Every register updates on the clock edge after its inputs are presented. The shared pin is a combinational select.

Top module: `term_status_ctl`

## Requirements
- R1: While `rstN` is low, `ctlRdData`, `lastStatus` and `basicStatus` are all zero.
- R2: A control write with bit 14 set, and no capture in that cycle, zeroes every bit of `lastStatus` except the address field (bits 15:11) and the busy flag (bit 3).
- R3: A control write with bit 5 set zeroes `lastStatus` bit 3 and changes no other bit of either status word.
- R4: Control bits 14 and 5 always read back as 0. Every other bit of `ctlRdData` takes the value written.
- R5: While stored control bit 6 is 0, each of `masterRst`, `swRst` and `modeRst` sets bit 3 of both `lastStatus` and `basicStatus`.
- R6: While stored control bit 6 is 1, `swRst` and `modeRst` leave both busy flags unchanged, and `masterRst` still sets them.
- R7: When a busy-set event and a bit-5 clear arrive in the same cycle, bit 3 of `lastStatus` ends at 1.
- R8: `masterRst` clears the whole control word to 0, even when a control write arrives in the same cycle.
- R9: `capEn` loads `capLast` into every bit of `lastStatus` except bit 3, and loads `basicData` into `basicStatus`. A capture takes priority over a bit-14 clear in the same cycle.
- R10: `discOrIrq` follows `storeDisc` when stored control bit 7 is 1, and follows `irqPrio` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWrEn | input | 1 | Host control write strobe |
| ctlWrData | input | 16 | Host control write data |
| ctlRdData | output | 16 | Control word readback |
| masterRst | input | 1 | Master reset event |
| swRst | input | 1 | Software reset event |
| modeRst | input | 1 | Reset mode command event |
| capEn | input | 1 | New status capture strobe |
| capLast | input | 16 | New last-status contents |
| basicData | input | 16 | New basic-status contents |
| lastStatus | output | 16 | Last-status word |
| basicStatus | output | 16 | Basic-status word |
| irqPrio | input | 1 | Interrupt-priority source |
| storeDisc | input | 1 | Store-disconnect source |
| discOrIrq | output | 1 | Shared output pin |

## Verification
The embedded assertions check the following on every cycle:
- A busy-set strobe leaves both busy flags high on the next cycle.
- A bit-5 clear with no set pending drops the last-status busy flag.
- A bit-14 clear keeps the address field while zeroing the other non-busy bits.
- A master reset leaves the control word at zero.
- The busy option suppresses the software and mode-command reset sources.

Other behaviour can only be shown by bench scenarios run against a reference model:
- The priority of capture over clear-last.
- The exact bits a capture loads.
- The written-value readback.
- The pin selection.

These scenarios include directed collisions of events in a single cycle.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef struct packed {
    logic clrLast;
    logic clrBusy;
    logic setBusy;
  } ctlStrobes_t;
endpackage

// File: rtl/tsr_ctl.sv
module tsr_ctl
  import tsr_pkg::*;
#(
  parameter int CTRL_W       = 16,
  parameter int CLR_LAST_BIT = 14,
  parameter int CLR_BUSY_BIT = 5,
  parameter int BUSY_OPT_BIT = 6,
  parameter int ALT_STD_BIT  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [CTRL_W-1:0] ctlWrData,
  input  logic              masterRst,
  input  logic              swRst,
  input  logic              modeRst,
  output logic [CTRL_W-1:0] ctlRdData,
  output logic              altStd,
  output ctlStrobes_t       strb
);
  logic [CTRL_W-1:0] ctlReg;
  logic              busyOpt;

  // one flop per storable bit; command bits are never stored
  for (genvar i = 0; i < CTRL_W; i++) begin : g_bit
    if (i == CLR_LAST_BIT || i == CLR_BUSY_BIT) begin : g_cmd
      assign ctlReg[i] = 1'b0;
    end else begin : g_cfg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          ctlReg[i] <= 1'b0;
        else if (masterRst) ctlReg[i] <= 1'b0;
        else if (ctlWrEn)   ctlReg[i] <= ctlWrData[i];
      end
    end
  end

  assign ctlRdData = ctlReg;
  assign busyOpt   = ctlReg[BUSY_OPT_BIT];
  assign altStd    = ctlReg[ALT_STD_BIT];

  always_comb begin
    strb.clrLast = ctlWrEn && ctlWrData[CLR_LAST_BIT];
    strb.clrBusy = ctlWrEn && ctlWrData[CLR_BUSY_BIT];
    strb.setBusy = masterRst || (!busyOpt && (swRst || modeRst));
  end

  AST_MRST_CLEARS_CTL: assert property (@(posedge clk) disable iff (!rstN)
    masterRst |=> ctlRdData == '0); // R8
  AST_OPT_MASKS_SOFT: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRdData[BUSY_OPT_BIT] && !masterRst) |-> !strb.setBusy); // R6
endmodule

// File: rtl/tsr_datapath.sv
module tsr_datapath
  import tsr_pkg::*;
#(
  parameter int STAT_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int ADDR_LSB = 11,
  parameter int BUSY_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              capEn,
  input  logic [STAT_W-1:0] capLast,
  input  logic [STAT_W-1:0] basicData,
  output logic [STAT_W-1:0] lastStatus,
  output logic [STAT_W-1:0] basicStatus
);
  localparam logic [STAT_W-1:0] ONE       = STAT_W'(1);
  localparam logic [STAT_W-1:0] ADDR_MASK = ((ONE << ADDR_W) - ONE) << ADDR_LSB;
  localparam logic [STAT_W-1:0] BUSY_MASK = ONE << BUSY_BIT;
  localparam logic [STAT_W-1:0] KEEP_MASK = ADDR_MASK | BUSY_MASK;

  logic [STAT_W-1:0] lastNext, basicNext;

  always_comb begin
    lastNext = lastStatus;
    if (capEn)             lastNext = (capLast & ~BUSY_MASK) | (lastStatus & BUSY_MASK);
    else if (strb.clrLast) lastNext = lastStatus & KEEP_MASK;
    if (strb.clrBusy)      lastNext[BUSY_BIT] = 1'b0;
    if (strb.setBusy)      lastNext[BUSY_BIT] = 1'b1;

    basicNext = capEn ? basicData : basicStatus;
    if (strb.setBusy)      basicNext[BUSY_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastStatus  <= '0;
      basicStatus <= '0;
    end else begin
      lastStatus  <= lastNext;
      basicStatus <= basicNext;
    end
  end

  AST_BUSY_SET_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    strb.setBusy |=> (lastStatus[BUSY_BIT] && basicStatus[BUSY_BIT])); // R5
  AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrBusy && !strb.setBusy) |=> !lastStatus[BUSY_BIT]); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrBusy && strb.setBusy) |=> lastStatus[BUSY_BIT]); // R7
  AST_CLR_LAST_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrLast && !capEn) |=> (((lastStatus & ~KEEP_MASK) == '0) &&
      ((lastStatus & ADDR_MASK) == $past(lastStatus & ADDR_MASK)))); // R2
endmodule

// File: rtl/term_status_ctl.sv
module term_status_ctl
  import tsr_pkg::*;
#(
  parameter int CTRL_W       = 16,
  parameter int STAT_W       = 16,
  parameter int ADDR_W       = 5,
  parameter int ADDR_LSB     = 11,
  parameter int BUSY_BIT     = 3,
  parameter int CLR_LAST_BIT = 14,
  parameter int CLR_BUSY_BIT = 5,
  parameter int BUSY_OPT_BIT = 6,
  parameter int ALT_STD_BIT  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [CTRL_W-1:0] ctlWrData,
  output logic [CTRL_W-1:0] ctlRdData,
  input  logic              masterRst,
  input  logic              swRst,
  input  logic              modeRst,
  input  logic              capEn,
  input  logic [STAT_W-1:0] capLast,
  input  logic [STAT_W-1:0] basicData,
  output logic [STAT_W-1:0] lastStatus,
  output logic [STAT_W-1:0] basicStatus,
  input  logic              irqPrio,
  input  logic              storeDisc,
  output logic              discOrIrq
);
  ctlStrobes_t strb;
  logic        altStd;

  tsr_ctl #(
    .CTRL_W(CTRL_W), .CLR_LAST_BIT(CLR_LAST_BIT), .CLR_BUSY_BIT(CLR_BUSY_BIT),
    .BUSY_OPT_BIT(BUSY_OPT_BIT), .ALT_STD_BIT(ALT_STD_BIT)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .masterRst(masterRst), .swRst(swRst), .modeRst(modeRst),
    .ctlRdData(ctlRdData), .altStd(altStd), .strb(strb)
  );

  tsr_datapath #(
    .STAT_W(STAT_W), .ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB), .BUSY_BIT(BUSY_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .capEn(capEn), .capLast(capLast),
    .basicData(basicData), .lastStatus(lastStatus), .basicStatus(basicStatus)
  );

  assign discOrIrq = altStd ? storeDisc : irqPrio;
endmodule

// File: tb/tb_term_status_ctl.sv
module tb_term_status_ctl;
  logic        clk = 1'b0;
  logic        rstN;
  logic        ctlWrEn, masterRst, swRst, modeRst, capEn, irqPrio, storeDisc;
  logic [15:0] ctlWrData, capLast, basicData;
  logic [15:0] ctlRdData, lastStatus, basicStatus;
  logic        discOrIrq;

  int nChecks = 0;
  int nBad    = 0;
  logic [15:0] mCtl, mLast, mBasic;

  always #2 clk = ~clk;

  term_status_ctl dut (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .masterRst(masterRst), .swRst(swRst), .modeRst(modeRst),
    .capEn(capEn), .capLast(capLast), .basicData(basicData),
    .lastStatus(lastStatus), .basicStatus(basicStatus),
    .irqPrio(irqPrio), .storeDisc(storeDisc), .discOrIrq(discOrIrq)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] nextCtl(input logic [15:0] c);
    if (masterRst) return 16'h0;
    if (ctlWrEn)   return ctlWrData & ~16'h4020;
    return c;
  endfunction

  function automatic logic setEv(input logic [15:0] c);
    return masterRst || (!c[6] && (swRst || modeRst));
  endfunction

  function automatic logic [15:0] nextLast(input logic [15:0] c, input logic [15:0] l);
    logic [15:0] n;
    n = l;
    if (capEn) n = {capLast[15:4], l[3], capLast[2:0]};
    else if (ctlWrEn && ctlWrData[14]) n = l & 16'hF808;
    if (ctlWrEn && ctlWrData[5]) n[3] = 1'b0;
    if (setEv(c)) n[3] = 1'b1;
    return n;
  endfunction

  function automatic logic [15:0] nextBasic(input logic [15:0] c, input logic [15:0] b);
    logic [15:0] n;
    n = capEn ? basicData : b;
    if (setEv(c)) n[3] = 1'b1;
    return n;
  endfunction

  task automatic idle();
    ctlWrEn = 0; ctlWrData = '0; masterRst = 0; swRst = 0; modeRst = 0;
    capEn = 0; capLast = '0; basicData = '0;
  endtask

  // inputs already set at negedge; advance one edge and compare
  task automatic step(input string req);
    logic [15:0] eC, eL, eB;
    eC = nextCtl(mCtl); eL = nextLast(mCtl, mLast); eB = nextBasic(mCtl, mBasic);
    @(posedge clk); #1;
    mCtl = eC; mLast = eL; mBasic = eB;
    check(ctlRdData, mCtl, {req, " ctl"});
    check(lastStatus, mLast, {req, " last"});
    check(basicStatus, mBasic, {req, " basic"});
    check({15'd0, discOrIrq}, {15'd0, mCtl[7] ? storeDisc : irqPrio}, "R10 pin");
    @(negedge clk);
    idle();
  endtask

  initial begin
    #400000;
    nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1553));
    idle(); irqPrio = 0; storeDisc = 1; rstN = 0;
    mCtl = '0; mLast = '0; mBasic = '0;
    repeat (3) @(negedge clk);
    check(ctlRdData, 16'h0, "R1 ctl");
    check(lastStatus, 16'h0, "R1 last");
    check(basicStatus, 16'h0, "R1 basic");
    rstN = 1;
    @(negedge clk);

    // R9 capture, then R2 clear keeps address and busy
    capEn = 1; capLast = 16'hFFFF; basicData = 16'h1234; step("R9 capture");
    masterRst = 1; step("R5 master sets busy");
    ctlWrEn = 1; ctlWrData = 16'h4000; step("R2 clear last");
    check(lastStatus, 16'hF808, "R2 kept bits");
    // R9 capture beats clear-last
    ctlWrEn = 1; ctlWrData = 16'h4000; capEn = 1; capLast = 16'h0A50; step("R9 cap over clr");
    // R4 readback
    ctlWrEn = 1; ctlWrData = 16'hFFFF; step("R4 readback");
    check(ctlRdData, 16'hBFDF, "R4 cmd bits zero");
    // R6 option set: sw/mode ignored
    ctlWrEn = 1; ctlWrData = 16'h0040; step("R6 set opt");
    ctlWrEn = 1; ctlWrData = 16'h0060; step("R3 clr busy");
    check({15'd0, lastStatus[3]}, 16'h0, "R3 busy low");
    swRst = 1; modeRst = 1; step("R6 soft ignored");
    check({15'd0, lastStatus[3]}, 16'h0, "R6 busy still low");
    // R7 master + clear-busy together, R8 master beats write
    masterRst = 1; ctlWrEn = 1; ctlWrData = 16'h00A0; step("R7 set wins");
    check({15'd0, lastStatus[3]}, 16'h1, "R7 busy high");
    check(ctlRdData, 16'h0, "R8 master clears ctl");
    // R5 with option 0: mode reset vs clear-busy
    modeRst = 1; ctlWrEn = 1; ctlWrData = 16'h0020; step("R5 R7 mode reset");
    // R10 pin both ways
    ctlWrEn = 1; ctlWrData = 16'h0080; step("R10 alt std");
    irqPrio = 1; storeDisc = 0; #1;
    check({15'd0, discOrIrq}, 16'h0, "R10 store disconnect");
    ctlWrEn = 1; ctlWrData = 16'h0000; step("R10 irq");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      ctlWrEn = r[0] & r[1]; ctlWrData = 16'($urandom);
      masterRst = (r[7:2] == 0); swRst = r[8] & r[9]; modeRst = r[10] & r[11];
      capEn = r[12] & r[13]; capLast = 16'($urandom); basicData = 16'($urandom);
      irqPrio = r[14]; storeDisc = r[15];
      step("R2 R3 R5 R6 R7 R9 random");
    end

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule